// File: doc/BRIEF.md
# Paired 8-bit Register File

This block holds the working registers of a small 8-bit processor: one accumulator, six general byte registers, and a 16-bit stack pointer. The six general registers are also reachable as three 16-bit pairs. The high byte of each pair is the first register of the pair. A caller selects one operation per cycle through a 3-bit operation code. The operations are a byte write, a pair write (immediate load), pair increment, pair decrement, addition of a pair into HL, and a one-step swap of HL with DE.

Reads are combinational and show the state before the coming clock edge. Byte reads use a 3-bit register index and pair reads use a 2-bit pair index. One byte index does not name a register. It stands for the memory byte that HL points at. The block always drives HL on its memory address output and flags when that index is in use. Memory access, instruction decode and flag logic sit outside this block. Only the carry out of the 16-bit add leaves the block.

Top module: `pairRegFile`

## Requirements
- R1: After reset every byte register, every pair and the stack pointer read zero.
- R2: A byte write (op 1) stores wrData8 into the register named by regSel, with indices B=0, C=1, D=2, E=3, H=4, L=5, A=7. A read in the same cycle returns the old value. The new value is visible after the clock edge.
- R3: Pair indices are BC=0, DE=1, HL=2, SP=3. A pair reads as {first register, second register}. A pair write (op 2) stores wrData16 into the pair named by pairSel, and both halves can then be read as bytes.
- R4: memAddr always equals HL. Index 6 is the memory slot: memSel is high when rdSel8 is 6, or when op is 1 with regSel 6. A byte read of index 6 returns 0, and a byte write to index 6 changes no register.
- R5: Increment (op 3) adds one to the pair or SP named by pairSel, and wraps FFFFh to 0000h.
- R6: Decrement (op 4) subtracts one from the pair or SP named by pairSel, and wraps 0000h to FFFFh.
- R7: Add (op 5) loads HL with HL plus the pair or SP named by pairSel, modulo 2^16. During that cycle carryOut shows bit 16 of the sum. Adding HL to itself doubles it.
- R8: Exchange (op 6) swaps the full contents of HL and DE at one clock edge.
- R9: carryOut is 0 in every cycle whose op is not 5, including an increment that wraps.
- R10: Ops 0 and 7 change nothing. Any op leaves untouched every register it does not target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation code: 0 none, 1 byte write, 2 pair write, 3 increment, 4 decrement, 5 add to HL, 6 swap HL/DE, 7 none |
| regSel | input | 3 | Byte write index |
| wrData8 | input | 8 | Byte write data |
| pairSel | input | 2 | Pair index for write, increment, decrement and add source |
| wrData16 | input | 16 | Pair write (immediate) data |
| rdSel8 | input | 3 | Byte read index |
| rdData8 | output | 8 | Byte read data |
| rdPairSel | input | 2 | Pair read index |
| rdData16 | output | 16 | Pair read data |
| memAddr | output | 16 | Current HL, the address of the memory slot |
| memSel | output | 1 | Memory slot index in use for read or write |
| carryOut | output | 1 | Carry out of the add-to-HL operation |

## Verification
The hardest state to reach is a wrap or carry that lands on a pair already changed by earlier operations. An example is the add of SP into HL after SP has been wrapped through zero and HL has been swapped with DE. The vector table builds this state step by step through the ports. It loads SP with FFFFh, wraps it up and then down, doubles HL into a carry, and swaps HL with DE. Each step reads back the result of the step before it, so a fault in any one step breaks the next expected value.

// File: rtl/prfPkg.sv
package prfPkg;
  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_WR8   = 3'd1;
  localparam logic [2:0] OP_WR16  = 3'd2;
  localparam logic [2:0] OP_INC   = 3'd3;
  localparam logic [2:0] OP_DEC   = 3'd4;
  localparam logic [2:0] OP_ADDHL = 3'd5;
  localparam logic [2:0] OP_XCHG  = 3'd6;

  localparam logic [2:0] IDX_MEM = 3'd6;
  localparam logic [2:0] IDX_ACC = 3'd7;
  localparam logic [1:0] PAIR_HL = 2'd2;

  localparam logic [1:0] ADD_INC  = 2'd0;
  localparam logic [1:0] ADD_DEC  = 2'd1;
  localparam logic [1:0] ADD_PAIR = 2'd2;

  typedef struct packed {
    logic [7:0] wr8;      // one-hot byte write, bit = register index
    logic [3:0] pairWr;   // one-hot pair write, bit = pair index
    logic       useAdder; // pair write takes adder result
    logic [1:0] addSel;   // adder second operand
    logic       xchg;     // swap HL and DE
  } strobeT;
endpackage

// File: rtl/prfCtrl.sv
module prfCtrl
  import prfPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] op,
  input  logic [2:0] regSel,
  input  logic [1:0] pairSel,
  input  logic [2:0] rdSel8,
  output strobeT     st,
  output logic       memSel
);
  always_comb begin
    st = '0;
    st.addSel = ADD_PAIR;
    unique case (op)
      OP_WR8:   if (regSel != IDX_MEM) st.wr8[regSel] = 1'b1;
      OP_WR16:  st.pairWr[pairSel] = 1'b1;
      OP_INC: begin
        st.pairWr[pairSel] = 1'b1;
        st.useAdder = 1'b1;
        st.addSel = ADD_INC;
      end
      OP_DEC: begin
        st.pairWr[pairSel] = 1'b1;
        st.useAdder = 1'b1;
        st.addSel = ADD_DEC;
      end
      OP_ADDHL: begin
        st.pairWr[PAIR_HL] = 1'b1;
        st.useAdder = 1'b1;
        st.addSel = ADD_PAIR;
      end
      OP_XCHG:  st.xchg = 1'b1;
      default:  st = st;
    endcase
  end

  assign memSel = (rdSel8 == IDX_MEM) || (op == OP_WR8 && regSel == IDX_MEM);

  // R2 / R4: at most one target per cycle, never the memory slot
  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.wr8, st.pairWr, st.xchg}) && !st.wr8[IDX_MEM]);
endmodule

// File: rtl/prfDatapath.sv
module prfDatapath
  import prfPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PAIR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            st,
  input  logic [1:0]        pairSel,
  input  logic [DATA_W-1:0] wrData8,
  input  logic [PAIR_W-1:0] wrData16,
  input  logic [2:0]        rdSel8,
  input  logic [1:0]        rdPairSel,
  output logic [DATA_W-1:0] rdData8,
  output logic [PAIR_W-1:0] rdData16,
  output logic [PAIR_W-1:0] memAddr,
  output logic              carryOut
);
  localparam int NUM_PAIRS = 3;

  logic [DATA_W-1:0] byteVal [8];
  logic [PAIR_W-1:0] pairVal [4];
  logic [DATA_W-1:0] accQ;
  logic [PAIR_W-1:0] spQ;
  logic [PAIR_W-1:0] opA, opB, newPair;
  logic [PAIR_W:0]   sum;

  // adder path shared by increment, decrement and add-to-HL
  always_comb begin
    opA = (st.addSel == ADD_PAIR) ? pairVal[PAIR_HL] : pairVal[pairSel];
    unique case (st.addSel)
      ADD_INC: opB = {{(PAIR_W-1){1'b0}}, 1'b1};
      ADD_DEC: opB = {PAIR_W{1'b1}};
      default: opB = pairVal[pairSel];
    endcase
    sum = {1'b0, opA} + {1'b0, opB};
    newPair = st.useAdder ? sum[PAIR_W-1:0] : wrData16;
  end

  assign carryOut = st.useAdder && (st.addSel == ADD_PAIR) && sum[PAIR_W];

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : gPair
    logic [DATA_W-1:0] hiQ, loQ;
    // pairs 1 (DE) and 2 (HL) swap with each other
    localparam int OTHER = NUM_PAIRS - i;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiQ <= '0;
        loQ <= '0;
      end else if (st.xchg && i != 0) begin
        {hiQ, loQ} <= pairVal[OTHER];
      end else if (st.pairWr[i]) begin
        {hiQ, loQ} <= newPair;
      end else begin
        if (st.wr8[2*i])   hiQ <= wrData8;
        if (st.wr8[2*i+1]) loQ <= wrData8;
      end
    end
    assign byteVal[2*i]   = hiQ;
    assign byteVal[2*i+1] = loQ;
    assign pairVal[i]     = {hiQ, loQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      spQ  <= '0;
    end else begin
      if (st.wr8[IDX_ACC]) accQ <= wrData8;
      if (st.pairWr[3])    spQ  <= newPair;
    end
  end

  assign byteVal[IDX_MEM] = '0;
  assign byteVal[IDX_ACC] = accQ;
  assign pairVal[3]       = spQ;

  assign rdData8  = byteVal[rdSel8];
  assign rdData16 = pairVal[rdPairSel];
  assign memAddr  = pairVal[PAIR_HL];

  assert_xchg_swap_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.xchg |=> (pairVal[2] == $past(pairVal[1])) && (pairVal[1] == $past(pairVal[2])));

  assert_acc_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !st.wr8[IDX_ACC] |=> accQ == $past(accQ));

  assert_sp_inc_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.useAdder && st.addSel == ADD_INC && st.pairWr[3]) |=> spQ == $past(spQ) + 1'b1);

  assert_sp_dec_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st.useAdder && st.addSel == ADD_DEC && st.pairWr[3]) |=> spQ == $past(spQ) - 1'b1);
endmodule

// File: rtl/pairRegFile.sv
module pairRegFile
  import prfPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PAIR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        op,
  input  logic [2:0]        regSel,
  input  logic [DATA_W-1:0] wrData8,
  input  logic [1:0]        pairSel,
  input  logic [PAIR_W-1:0] wrData16,
  input  logic [2:0]        rdSel8,
  output logic [DATA_W-1:0] rdData8,
  input  logic [1:0]        rdPairSel,
  output logic [PAIR_W-1:0] rdData16,
  output logic [PAIR_W-1:0] memAddr,
  output logic              memSel,
  output logic              carryOut
);
  strobeT st;

  prfCtrl uCtrl (
    .clk(clk), .rstN(rstN), .op(op), .regSel(regSel), .pairSel(pairSel),
    .rdSel8(rdSel8), .st(st), .memSel(memSel)
  );

  prfDatapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .pairSel(pairSel), .wrData8(wrData8),
    .wrData16(wrData16), .rdSel8(rdSel8), .rdPairSel(rdPairSel),
    .rdData8(rdData8), .rdData16(rdData16), .memAddr(memAddr),
    .carryOut(carryOut)
  );

  assert_no_carry_R9: assert property (@(posedge clk) disable iff (!rstN)
    (op != OP_ADDHL) |-> !carryOut);

  assert_hl_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdPairSel == PAIR_HL) |-> memAddr == rdData16);
endmodule

// File: tb/pairRegFile_test.sv
module pairRegFile_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  op = 3'd0, regSel = 3'd0, rdSel8 = 3'd0;
  logic [7:0]  wrData8 = 8'd0;
  logic [1:0]  pairSel = 2'd0, rdPairSel = 2'd0;
  logic [15:0] wrData16 = 16'd0;
  logic [7:0]  rdData8;
  logic [15:0] rdData16, memAddr;
  logic        memSel, carryOut;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pairRegFile uut (
    .clk(clk), .rstN(rstN), .op(op), .regSel(regSel), .wrData8(wrData8),
    .pairSel(pairSel), .wrData16(wrData16), .rdSel8(rdSel8), .rdData8(rdData8),
    .rdPairSel(rdPairSel), .rdData16(rdData16), .memAddr(memAddr),
    .memSel(memSel), .carryOut(carryOut)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic [2:0]  regSel;
    logic [7:0]  d8;
    logic [1:0]  pairSel;
    logic [15:0] d16;
    logic [2:0]  rd8;
    logic [1:0]  rdp;
    logic [7:0]  exp8;
    logic [15:0] exp16;
    logic        expC;
  } vecT;

  localparam int NV = 21;
  // each row: outputs sampled before the edge that applies its op
  localparam vecT TABLE [NV] = '{
    '{4'd1, 3'd0, 3'd0, 8'h00, 2'd0, 16'h0000, 3'd7, 2'd3, 8'h00, 16'h0000, 1'b0}, // R1
    '{4'd2, 3'd1, 3'd0, 8'h12, 2'd0, 16'h0000, 3'd0, 2'd0, 8'h00, 16'h0000, 1'b0}, // R2 old value
    '{4'd2, 3'd1, 3'd1, 8'h34, 2'd0, 16'h0000, 3'd0, 2'd0, 8'h12, 16'h1200, 1'b0}, // R2
    '{4'd3, 3'd1, 3'd7, 8'h5A, 2'd0, 16'h0000, 3'd1, 2'd0, 8'h34, 16'h1234, 1'b0}, // R3
    '{4'd2, 3'd2, 3'd0, 8'h00, 2'd1, 16'hABCD, 3'd7, 2'd1, 8'h5A, 16'h0000, 1'b0}, // R2
    '{4'd3, 3'd2, 3'd0, 8'h00, 2'd2, 16'h8001, 3'd2, 2'd1, 8'hAB, 16'hABCD, 1'b0}, // R3
    '{4'd3, 3'd2, 3'd0, 8'h00, 2'd3, 16'hFFFF, 3'd5, 2'd2, 8'h01, 16'h8001, 1'b0}, // R3
    '{4'd9, 3'd3, 3'd0, 8'h00, 2'd3, 16'h0000, 3'd4, 2'd3, 8'h80, 16'hFFFF, 1'b0}, // R9 inc wrap
    '{4'd5, 3'd4, 3'd0, 8'h00, 2'd0, 16'h0000, 3'd3, 2'd3, 8'hCD, 16'h0000, 1'b0}, // R5
    '{4'd6, 3'd0, 3'd0, 8'h00, 2'd0, 16'h0000, 3'd0, 2'd0, 8'h12, 16'h1233, 1'b0}, // R6
    '{4'd7, 3'd5, 3'd0, 8'h00, 2'd2, 16'h0000, 3'd7, 2'd2, 8'h5A, 16'h8001, 1'b1}, // R7 HL+HL
    '{4'd7, 3'd5, 3'd0, 8'h00, 2'd0, 16'h0000, 3'd7, 2'd2, 8'h5A, 16'h0002, 1'b0}, // R7
    '{4'd8, 3'd6, 3'd0, 8'h00, 2'd0, 16'h0000, 3'd7, 2'd2, 8'h5A, 16'h1235, 1'b0}, // R8
    '{4'd8, 3'd0, 3'd0, 8'h00, 2'd0, 16'h0000, 3'd4, 2'd2, 8'hAB, 16'hABCD, 1'b0}, // R8
    '{4'd8, 3'd0, 3'd0, 8'h00, 2'd0, 16'h0000, 3'd2, 2'd1, 8'h12, 16'h1235, 1'b0}, // R8
    '{4'd6, 3'd4, 3'd0, 8'h00, 2'd3, 16'h0000, 3'd7, 2'd3, 8'h5A, 16'h0000, 1'b0}, // R6
    '{4'd4, 3'd1, 3'd6, 8'hEE, 2'd0, 16'h0000, 3'd6, 2'd3, 8'h00, 16'hFFFF, 1'b0}, // R4
    '{4'd4, 3'd0, 3'd0, 8'h00, 2'd0, 16'h0000, 3'd4, 2'd2, 8'hAB, 16'hABCD, 1'b0}, // R4
    '{4'd10,3'd7, 3'd7, 8'h99, 2'd2, 16'h1111, 3'd7, 2'd0, 8'h5A, 16'h1233, 1'b0}, // R10
    '{4'd7, 3'd5, 3'd0, 8'h00, 2'd3, 16'h0000, 3'd7, 2'd2, 8'h5A, 16'hABCD, 1'b1}, // R7
    '{4'd7, 3'd0, 3'd0, 8'h00, 2'd0, 16'h0000, 3'd7, 2'd2, 8'h5A, 16'hABCC, 1'b0}  // R7
  };

  task automatic check(input int req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      op = TABLE[i].op; regSel = TABLE[i].regSel; wrData8 = TABLE[i].d8;
      pairSel = TABLE[i].pairSel; wrData16 = TABLE[i].d16;
      rdSel8 = TABLE[i].rd8; rdPairSel = TABLE[i].rdp;
      #2;
      check(int'(TABLE[i].req), "rdData8", {8'h00, rdData8}, {8'h00, TABLE[i].exp8});
      check(int'(TABLE[i].req), "rdData16", rdData16, TABLE[i].exp16);
      check(int'(TABLE[i].req), "carryOut", {15'd0, carryOut}, {15'd0, TABLE[i].expC});
      @(negedge clk);
    end
    // R4: memory slot address and select
    op = 3'd0; rdSel8 = 3'd6; #2;
    check(4, "memAddr is HL", memAddr, 16'hABCC);
    check(4, "memSel on read of slot", {15'd0, memSel}, 16'd1);
    rdSel8 = 3'd0; #1;
    check(4, "memSel idle", {15'd0, memSel}, 16'd0);
    op = 3'd1; regSel = 3'd6; #1;
    check(4, "memSel on write of slot", {15'd0, memSel}, 16'd1);
    @(negedge clk);
    op = 3'd0; rdSel8 = 3'd0; #2;
    check(10, "B after slot write", {8'h00, rdData8}, 16'h0012);
    // R1: reset in mid-run clears everything
    rstN = 1'b0; #1;
    for (int p = 0; p < 4; p++) begin
      rdPairSel = 2'(p); #1;
      check(1, "pair after reset", rdData16, 16'h0000);
    end
    rdSel8 = 3'd7; #1;
    check(1, "A after reset", {8'h00, rdData8}, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    finish();
  end
endmodule